// File: doc/BRIEF.md
# PHY Receive Event Statistics Counters

This block keeps three statistics counters for a 100 Mb/s physical layer: one for link disconnect events, one for false carrier events and one for received packets that carried errors. It does no symbol decoding or carrier sensing of its own. It takes indications that are already decoded: a disconnect pulse, carrier detect, start-delimiter detect, a receive frame envelope, a receive error flag and a collision flag.

The three counters follow three overflow policies. The disconnect counter wraps. The false carrier counter saturates. The receive-error counter wraps, and it counts qualifying packets once each at the end of the frame, not error cycles.

A carrier assertion is judged false when it ends, or when a fixed window of carrier cycles runs out, with no start delimiter seen. Software reads any counter through a combinational read port. A read does not clear the counter. A synchronous clear input zeroes all three counters at once.

Top module: `phy_evt_counters`

## Requirements
- R1: The disconnect counter (read address 0) adds one for each rising edge of `discPulse`. A pulse held high for several cycles counts once. The new value can be read in the cycle after the edge is sampled.
- R2: The disconnect counter wraps from its all-ones value (CNT_W bits, 16 by default) to zero.
- R3: The false carrier counter (read address 1) adds one when a carrier assertion ends with no `jkSeen` in any of its cycles. `jkSeen` in the first carrier cycle also cancels the event.
- R4: A carrier assertion that stays high for FC_WINDOW cycles with no `jkSeen` is counted in its FC_WINDOW-th cycle. It is never counted a second time, however long it lasts.
- R5: The false carrier counter saturates at all ones and does not wrap.
- R6: The receive-error counter (read address 2) adds one in the cycle after `rxFrame` falls, if `rxErr` was high in any cycle while `rxFrame` was high. It adds at most one per frame.
- R7: A frame in which `rxCol` was high in any cycle is not counted. `rxErr` outside a frame is ignored. The error and collision flags are cleared when the next frame starts.
- R8: The receive-error counter wraps from all ones to zero.
- R9: Read address 3 returns zero. Reads are combinational and never change a counter value.
- R10: All counters are zero after reset. `clrAll` zeroes all three on the next edge, and it takes precedence over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clrAll | input | 1 | Synchronous clear of all counters |
| discPulse | input | 1 | Disconnect event indication |
| carrierOn | input | 1 | Carrier detect |
| jkSeen | input | 1 | Start-delimiter detected |
| rxFrame | input | 1 | Receive frame envelope |
| rxErr | input | 1 | Receive error indication |
| rxCol | input | 1 | Collision indication |
| rdAddr | input | 2 | Counter select: 0 disconnect, 1 false carrier, 2 receive error, 3 zero |
| rdData | output | CNT_W | Selected counter value |

## Verification
The hardest states to reach from the ports are the overflow boundaries. A full-width counter needs tens of thousands of events before it wraps or saturates, so the bench builds the block with a narrow counter width and drives hundreds of short carrier bursts and error frames to cross each boundary. The false carrier window expiring in the same assertion that later ends is also hard to reach. The bench gets there by holding carrier for exactly FC_WINDOW cycles and then longer, and shows that a single event is recorded. Collision suppression and flag clearing are reached with back-to-back frames whose error, collision and clean cycles are arranged so that a stale sticky flag would change the count.

// File: rtl/phy_evt_pkg.sv
package phy_evt_pkg;
  localparam int NUM_CNT = 3;
  localparam int IDX_DISC = 0;
  localparam int IDX_FALSE = 1;
  localparam int IDX_RXERR = 2;

  typedef struct packed {
    logic clr;
    logic [NUM_CNT-1:0] inc;
  } evtStrobe_t;

  function automatic bit isSaturating(int idx);
    return idx == IDX_FALSE;
  endfunction
endpackage

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import phy_evt_pkg::*;
#(
  parameter int FC_WINDOW = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clrAll,
  input  logic       discPulse,
  input  logic       carrierOn,
  input  logic       jkSeen,
  input  logic       rxFrame,
  input  logic       rxErr,
  input  logic       rxCol,
  output evtStrobe_t strobe
);
  localparam int WIN_W = (FC_WINDOW > 1) ? $clog2(FC_WINDOW) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(FC_WINDOW - 1);

  logic discPrev, carrierPrev, framePrev;
  logic judging;
  logic [WIN_W-1:0] winCnt, effCnt;
  logic errSticky, colSticky, errNext, colNext;
  logic carrierRise, active, expire, falseEvt, judgingNext;
  logic frameRise, frameFall;

  // false carrier judgement
  always_comb begin
    carrierRise = carrierOn & ~carrierPrev;
    active      = judging | carrierRise;
    effCnt      = carrierRise ? '0 : winCnt;
    expire      = carrierOn & (effCnt == WIN_LAST);
    falseEvt    = active & ~jkSeen & (~carrierOn | expire);
    judgingNext = active & ~jkSeen & carrierOn & ~expire;
  end

  // per-frame error qualification
  always_comb begin
    frameRise = rxFrame & ~framePrev;
    frameFall = ~rxFrame & framePrev;
    if (frameRise) begin
      errNext = rxErr;
      colNext = rxCol;
    end else begin
      errNext = errSticky | (rxFrame & rxErr);
      colNext = colSticky | (rxFrame & rxCol);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      discPrev    <= 1'b0;
      carrierPrev <= 1'b0;
      framePrev   <= 1'b0;
      judging     <= 1'b0;
      winCnt      <= '0;
      errSticky   <= 1'b0;
      colSticky   <= 1'b0;
    end else begin
      discPrev    <= discPulse;
      carrierPrev <= carrierOn;
      framePrev   <= rxFrame;
      judging     <= judgingNext;
      winCnt      <= effCnt + 1'b1;
      errSticky   <= errNext;
      colSticky   <= colNext;
    end
  end

  always_comb begin
    strobe.clr            = clrAll;
    strobe.inc            = '0;
    strobe.inc[IDX_DISC]  = discPulse & ~discPrev;
    strobe.inc[IDX_FALSE] = falseEvt;
    strobe.inc[IDX_RXERR] = frameFall & errSticky & ~colSticky;
  end
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W    = 16,
  parameter bit SATURATE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] value
);
  logic atMax;
  assign atMax = &value;

  generate
    if (SATURATE) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             value <= '0;
        else if (clr)           value <= '0;
        else if (inc && !atMax) value <= value + 1'b1;
      end
    end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   value <= '0;
        else if (clr) value <= '0;
        else if (inc) value <= value + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/evt_datapath.sv
module evt_datapath
  import phy_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  evtStrobe_t                      strobe,
  input  logic [1:0]                      rdAddr,
  output logic [CNT_W-1:0]                rdData,
  output logic [NUM_CNT-1:0][CNT_W-1:0]   cntOut
);
  generate
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      evt_counter #(
        .CNT_W   (CNT_W),
        .SATURATE(isSaturating(i))
      ) cnt_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (strobe.clr),
        .inc  (strobe.inc[i]),
        .value(cntOut[i])
      );
    end
  endgenerate

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (rdAddr == 2'(i)) rdData = cntOut[i];
    end
  end
endmodule

// File: rtl/phy_evt_counters.sv
module phy_evt_counters
  import phy_evt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int FC_WINDOW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clrAll,
  input  logic             discPulse,
  input  logic             carrierOn,
  input  logic             jkSeen,
  input  logic             rxFrame,
  input  logic             rxErr,
  input  logic             rxCol,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData
);
  evtStrobe_t strobe;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntOut;

  evt_ctrl #(.FC_WINDOW(FC_WINDOW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .clrAll(clrAll), .discPulse(discPulse),
    .carrierOn(carrierOn), .jkSeen(jkSeen), .rxFrame(rxFrame),
    .rxErr(rxErr), .rxCol(rxCol), .strobe(strobe)
  );

  evt_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rdAddr(rdAddr),
    .rdData(rdData), .cntOut(cntOut)
  );
endmodule

// File: rtl/phy_evt_counters_chk.sv
module phy_evt_counters_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clrAll,
  input logic             discPulse,
  input logic             rxFrame,
  input logic [CNT_W-1:0] dCnt,
  input logic [CNT_W-1:0] fCnt,
  input logic [CNT_W-1:0] rCnt
);
  // R1, R2: disconnect count only steps by one (modulo width), on a rising edge
  a_r2_disc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clrAll) && dCnt != $past(dCnt)) |-> dCnt == CNT_W'($past(dCnt) + 1'b1));
  a_r1_disc_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clrAll) && dCnt != $past(dCnt)) |-> $past(discPulse));
  // R5: saturated false carrier count holds
  a_r5_fc_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clrAll) && &$past(fCnt)) |-> &fCnt);
  // R6: receive-error count moves only after the frame envelope falls
  a_r6_rx_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clrAll) && rCnt != $past(rCnt)) |-> (!$past(rxFrame) && $past(rxFrame, 2)));
  // R10: clear zeroes every counter
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clrAll) |-> (dCnt == '0 && fCnt == '0 && rCnt == '0));
endmodule

bind phy_evt_counters phy_evt_counters_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .clrAll(clrAll), .discPulse(discPulse),
  .rxFrame(rxFrame), .dCnt(cntOut[0]), .fCnt(cntOut[1]), .rCnt(cntOut[2])
);

// File: tb/phy_evt_counters_tb_top.sv
`timescale 1ns/100ps
module phy_evt_counters_tb_top;
  localparam int W = 8;
  localparam int WIN = 4;
  localparam int NV = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clrAll = 0, discPulse = 0, carrierOn = 0, jkSeen = 0;
  logic rxFrame = 0, rxErr = 0, rxCol = 0;
  logic [1:0] rdAddr = 0;
  logic [W-1:0] rdData;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  phy_evt_counters #(.CNT_W(W), .FC_WINDOW(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .clrAll(clrAll), .discPulse(discPulse),
    .carrierOn(carrierOn), .jkSeen(jkSeen), .rxFrame(rxFrame),
    .rxErr(rxErr), .rxCol(rxCol), .rdAddr(rdAddr), .rdData(rdData)
  );

  // inputs {disc,car,jk,frame,err,col}, expected {disc,false,rxerr}
  localparam logic [29:0] VEC [NV] = '{
    {6'b100000, 8'd1, 8'd0, 8'd0}, {6'b100000, 8'd1, 8'd0, 8'd0},
    {6'b000000, 8'd1, 8'd0, 8'd0}, {6'b100000, 8'd2, 8'd0, 8'd0},
    {6'b010000, 8'd2, 8'd0, 8'd0}, {6'b011000, 8'd2, 8'd0, 8'd0},
    {6'b010000, 8'd2, 8'd0, 8'd0}, {6'b000000, 8'd2, 8'd0, 8'd0},
    {6'b010000, 8'd2, 8'd0, 8'd0}, {6'b000000, 8'd2, 8'd1, 8'd0},
    {6'b011000, 8'd2, 8'd1, 8'd0}, {6'b000000, 8'd2, 8'd1, 8'd0},
    {6'b010000, 8'd2, 8'd1, 8'd0}, {6'b010000, 8'd2, 8'd1, 8'd0},
    {6'b010000, 8'd2, 8'd1, 8'd0}, {6'b010000, 8'd2, 8'd2, 8'd0},
    {6'b010000, 8'd2, 8'd2, 8'd0}, {6'b000000, 8'd2, 8'd2, 8'd0},
    {6'b000100, 8'd2, 8'd2, 8'd0}, {6'b000110, 8'd2, 8'd2, 8'd0},
    {6'b000000, 8'd2, 8'd2, 8'd1}, {6'b000100, 8'd2, 8'd2, 8'd1},
    {6'b000000, 8'd2, 8'd2, 8'd1}, {6'b000110, 8'd2, 8'd2, 8'd1},
    {6'b000101, 8'd2, 8'd2, 8'd1}, {6'b000000, 8'd2, 8'd2, 8'd1},
    {6'b000100, 8'd2, 8'd2, 8'd1}, {6'b000110, 8'd2, 8'd2, 8'd1},
    {6'b000000, 8'd2, 8'd2, 8'd2}, {6'b000010, 8'd2, 8'd2, 8'd2},
    {6'b000100, 8'd2, 8'd2, 8'd2}, {6'b000000, 8'd2, 8'd2, 8'd2}
  };

  task automatic drive(input logic [5:0] v);
    {discPulse, carrierOn, jkSeen, rxFrame, rxErr, rxCol} = v;
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    rdAddr = a;
    #0.2;
    v = rdData;
  endtask

  task automatic chk(input string tag, input logic [1:0] a, input logic [W-1:0] exp);
    logic [W-1:0] v;
    rd(a, v);
    checks++;
    if (v !== exp) begin
      errors++;
      $display("FAIL %s addr %0d: actual %0d expected %0d", tag, a, v, exp);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state, R9 unused address
    chk("R10 reset disc", 2'd0, 8'd0);
    chk("R10 reset false", 2'd1, 8'd0);
    chk("R10 reset rxerr", 2'd2, 8'd0);
    chk("R9 addr3 zero", 2'd3, 8'd0);

    // table: R1 R3 R4 R6 R7
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][29:24]);
      chk($sformatf("R1 table row %0d", i), 2'd0, VEC[i][23:16]);
      chk($sformatf("R3 R4 table row %0d", i), 2'd1, VEC[i][15:8]);
      chk($sformatf("R6 R7 table row %0d", i), 2'd2, VEC[i][7:0]);
    end

    // R9 reads do not clear
    chk("R9 reread disc", 2'd0, 8'd2);
    drive(6'b000000);
    chk("R9 reread disc again", 2'd0, 8'd2);
    chk("R9 addr3 with nonzero counters", 2'd3, 8'd0);

    // R10 clear wins over simultaneous increment
    clrAll = 1'b1;
    drive(6'b100000);
    clrAll = 1'b0;
    chk("R10 clear vs inc disc", 2'd0, 8'd0);
    chk("R10 clear false", 2'd1, 8'd0);
    chk("R10 clear rxerr", 2'd2, 8'd0);
    drive(6'b000000);

    // R2 disconnect wrap
    for (int i = 0; i < 255; i++) begin
      drive(6'b100000);
      drive(6'b000000);
    end
    chk("R2 disc at max", 2'd0, 8'd255);
    drive(6'b100000);
    drive(6'b000000);
    chk("R2 disc wrapped", 2'd0, 8'd0);

    // R5 false carrier saturation
    for (int i = 0; i < 300; i++) begin
      drive(6'b010000);
      drive(6'b000000);
    end
    chk("R5 false saturated", 2'd1, 8'd255);
    drive(6'b010000);
    drive(6'b000000);
    chk("R5 false stays saturated", 2'd1, 8'd255);

    // R8 receive-error wrap
    for (int i = 0; i < 255; i++) begin
      drive(6'b000110);
      drive(6'b000000);
    end
    chk("R8 rxerr at max", 2'd2, 8'd255);
    drive(6'b000110);
    drive(6'b000000);
    chk("R8 rxerr wrapped", 2'd2, 8'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule